// File: doc/BRIEF.md
# Latched Active-Low Interrupt Generator

This block gathers the event sources of a low-speed serial bus bridge and turns them into one active-low interrupt toward an attached microcontroller. The interrupt shares the serial data output pin: while the mode select line is high, the block drives that pin, and it pulls the pin low whenever an interrupt is pending. While the mode select line is low, the block releases the pin so that the serial shifter can drive it.

The sources are the three endpoint done flags, the bus resume and bus reset events, and a wake pin. The wake pin counts only while at least one of the two stop-state configuration bits is set. Once an interrupt is pending, it stays latched until the microcontroller finishes reading the status byte. An event that arrives during that read is held back, so the line goes low again as soon as the read ends and the next read shows the event.

Top module: `lsb_irq_gen`

## Requirements
- R1: After reset nothing is pending: with the mode select high, `irq_n` reads 1 and `irq_oe` reads 1.
- R2: While `irq_mode` is 0, `irq_oe` is 0 and `irq_n` is 1, whatever is pending. Raising `irq_mode` shows the latched state again.
- R3: A high level on any bit of `done_flags` in a cycle outside a status read makes the interrupt pending. `irq_n` goes low after the next clock edge. Bit 0 is the OUT-done flag, bit 1 is endpoint-0 IN done and bit 2 is endpoint-1/2 IN done, and each bit acts alone.
- R4: `bus_resume` and `bus_reset` each set the pending interrupt in the same way.
- R5: `wake_in` sets the pending interrupt only when `stop_osc_cfg` or `stop_clk_cfg` is 1. When both are 0, it has no effect.
- R6: A pending interrupt holds `irq_n` low after its source drops, and it stays low throughout a status read until the cycle in which the read completes.
- R7: A clock edge with `stat_rd_end` high clears the pending interrupt when no event was held and no event is present in that cycle. `irq_n` returns to 1 after that edge.
- R8: An event in a cycle with `stat_rd_busy` high and `stat_rd_end` low is held. After the read completes it is pending, so `irq_n` stays low until a further read.
- R9: An event present in the same cycle as `stat_rd_end` stays pending after the clear.
- R10: Several events, at the same time or in sequence, merge into one pending interrupt that a single completed read clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_mode | input | 1 | 1: the data output pin carries the interrupt |
| done_flags | input | 3 | Endpoint done flags: bit0 OUT, bit1 EP0 IN, bit2 EP1/2 IN |
| wake_in | input | 1 | Wake pin level |
| stop_osc_cfg | input | 1 | Stop-oscillator configuration bit |
| stop_clk_cfg | input | 1 | Stop-microcontroller-clock configuration bit |
| bus_resume | input | 1 | Bus resume event |
| bus_reset | input | 1 | Bus reset event |
| stat_rd_busy | input | 1 | A status byte read is in progress |
| stat_rd_end | input | 1 | Last cycle of the status byte read |
| irq_n | output | 1 | Interrupt level toward the data output pin, active low |
| irq_oe | output | 1 | Drive enable for the data output pin |

## Verification
`irq_n` and `irq_oe` follow `irq_mode` and the latch directly, so mode changes show up in the same cycle. Any source or read-end takes effect through one register, so its result is due one clock edge after the cycle in which it was applied. The bench changes inputs on the falling edge. It then checks on the following falling edge, after exactly one rising edge, and for hold behaviour it checks again after several more edges. Held events are checked after the read-end edge, and once more after a second read has cleared them.

// File: rtl/lsb_irq_pkg.sv
package lsb_irq_pkg;

  typedef struct packed {
    logic pend;
    logic held;
  } irq_state_t;

  // Wake is meaningful only in a stop state.
  function automatic logic wake_qualified(input logic wake, input logic stop_osc,
                                          input logic stop_clk);
    return wake & (stop_osc | stop_clk);
  endfunction

  // Next latch state from the current state, the merged event and the read phase.
  function automatic irq_state_t latch_next(input irq_state_t cur, input logic ev,
                                            input logic busy, input logic rd_end);
    irq_state_t n;
    if (rd_end) begin
      n.pend = cur.held | ev;
      n.held = 1'b0;
    end else if (busy) begin
      n.pend = cur.pend;
      n.held = cur.held | ev;
    end else begin
      n.pend = cur.pend | cur.held | ev;
      n.held = 1'b0;
    end
    return n;
  endfunction

endpackage

// File: rtl/lsb_irq_src_merge.sv
module lsb_irq_src_merge #(
  parameter int unsigned DONE_W = 3
) (
  input  logic [DONE_W-1:0] done_flags,
  input  logic              wake_in,
  input  logic              stop_osc_cfg,
  input  logic              stop_clk_cfg,
  input  logic              bus_resume,
  input  logic              bus_reset,
  output logic              ev_any,
  output logic              wake_ok
);
  import lsb_irq_pkg::*;

  localparam int unsigned SRC_W = DONE_W + 3;

  logic [SRC_W-1:0] src_vec;

  always_comb begin
    wake_ok = wake_qualified(wake_in, stop_osc_cfg, stop_clk_cfg);
    src_vec = {wake_ok, bus_resume, bus_reset, done_flags};
    ev_any  = |src_vec;
  end
endmodule

// File: rtl/lsb_irq_latch.sv
module lsb_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_any,
  input  logic rd_busy,
  input  logic rd_end,
  output logic pending,
  output logic held
);
  import lsb_irq_pkg::*;

  irq_state_t st_q, st_d;

  always_comb st_d = latch_next(st_q, ev_any, rd_busy, rd_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign pending = st_q.pend;
  assign held    = st_q.held;
endmodule

// File: rtl/lsb_irq_pin.sv
module lsb_irq_pin (
  input  logic mode,
  input  logic pending,
  output logic pin_n,
  output logic pin_oe
);
  always_comb begin
    pin_oe = mode;
    pin_n  = mode ? ~pending : 1'b1;
  end
endmodule

// File: rtl/lsb_irq_gen.sv
module lsb_irq_gen #(
  parameter int unsigned DONE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_mode,
  input  logic [DONE_W-1:0] done_flags,
  input  logic              wake_in,
  input  logic              stop_osc_cfg,
  input  logic              stop_clk_cfg,
  input  logic              bus_resume,
  input  logic              bus_reset,
  input  logic              stat_rd_busy,
  input  logic              stat_rd_end,
  output logic              irq_n,
  output logic              irq_oe
);
  logic ev_any;
  logic wake_ok;
  logic pending;
  logic held;

  lsb_irq_src_merge #(.DONE_W(DONE_W)) u_merge (
    .done_flags  (done_flags),
    .wake_in     (wake_in),
    .stop_osc_cfg(stop_osc_cfg),
    .stop_clk_cfg(stop_clk_cfg),
    .bus_resume  (bus_resume),
    .bus_reset   (bus_reset),
    .ev_any      (ev_any),
    .wake_ok     (wake_ok)
  );

  lsb_irq_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_any (ev_any),
    .rd_busy(stat_rd_busy),
    .rd_end (stat_rd_end),
    .pending(pending),
    .held   (held)
  );

  lsb_irq_pin u_pin (
    .mode   (irq_mode),
    .pending(pending),
    .pin_n  (irq_n),
    .pin_oe (irq_oe)
  );
endmodule

// File: rtl/lsb_irq_gen_chk.sv
module lsb_irq_gen_chk #(
  parameter int unsigned DONE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_mode,
  input logic [DONE_W-1:0] done_flags,
  input logic              wake_in,
  input logic              stop_osc_cfg,
  input logic              stop_clk_cfg,
  input logic              bus_resume,
  input logic              bus_reset,
  input logic              stat_rd_busy,
  input logic              stat_rd_end,
  input logic              irq_n,
  input logic              irq_oe,
  input logic              ev_any,
  input logic              pending,
  input logic              held
);
  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mode |-> (!irq_oe && irq_n));

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|done_flags) && !stat_rd_busy && !stat_rd_end) |=> pending);

  p_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_resume || bus_reset) && !stat_rd_busy && !stat_rd_end) |=> pending);

  p_wake_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|done_flags) && !bus_resume && !bus_reset && !stop_osc_cfg && !stop_clk_cfg)
      |-> !ev_any);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !stat_rd_end) |=> pending);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_end && !held && !ev_any) |=> !pending);

  p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_busy && !stat_rd_end && ev_any) |=> held);

  p_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_end && ev_any) |=> pending);
endmodule

bind lsb_irq_gen lsb_irq_gen_chk #(.DONE_W(DONE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_mode    (irq_mode),
  .done_flags  (done_flags),
  .wake_in     (wake_in),
  .stop_osc_cfg(stop_osc_cfg),
  .stop_clk_cfg(stop_clk_cfg),
  .bus_resume  (bus_resume),
  .bus_reset   (bus_reset),
  .stat_rd_busy(stat_rd_busy),
  .stat_rd_end (stat_rd_end),
  .irq_n       (irq_n),
  .irq_oe      (irq_oe),
  .ev_any      (ev_any),
  .pending     (pending),
  .held        (held)
);

// File: tb/test_lsb_irq_gen.sv
module test_lsb_irq_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq_mode = 1'b1;
  logic [2:0] done_flags = '0;
  logic       wake_in = 1'b0, stop_osc_cfg = 1'b0, stop_clk_cfg = 1'b0;
  logic       bus_resume = 1'b0, bus_reset = 1'b0;
  logic       stat_rd_busy = 1'b0, stat_rd_end = 1'b0;
  logic       irq_n, irq_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsb_irq_gen i_lsb_irq_gen (
    .clk(clk), .rst_n(rst_n), .irq_mode(irq_mode), .done_flags(done_flags),
    .wake_in(wake_in), .stop_osc_cfg(stop_osc_cfg), .stop_clk_cfg(stop_clk_cfg),
    .bus_resume(bus_resume), .bus_reset(bus_reset),
    .stat_rd_busy(stat_rd_busy), .stat_rd_end(stat_rd_end),
    .irq_n(irq_n), .irq_oe(irq_oe)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  // Completed status read with no events inside it.
  task automatic plain_read();
    stat_rd_busy = 1'b1; step(); step();
    stat_rd_end = 1'b1; step();
    stat_rd_busy = 1'b0; stat_rd_end = 1'b0;
  endtask

  task automatic t_reset();
    check(irq_n, 1'b1, "R1 irq_n after reset");
    check(irq_oe, 1'b1, "R1 irq_oe after reset");
  endtask

  task automatic t_release();
    irq_mode = 1'b0; bus_resume = 1'b1; step(); bus_resume = 1'b0; step();
    check(irq_oe, 1'b0, "R2 oe released");
    check(irq_n, 1'b1, "R2 pin high while released");
    irq_mode = 1'b1; #1;
    check(irq_n, 1'b0, "R2 pending shown after mode high");
    plain_read();
    check(irq_n, 1'b1, "R7 cleared after read");
  endtask

  task automatic t_done();
    for (int i = 0; i < 3; i++) begin
      done_flags = 3'b001 << i; step(); done_flags = '0;
      check(irq_n, 1'b0, $sformatf("R3 done bit %0d", i));
      plain_read();
      check(irq_n, 1'b1, "R7 clear after done");
    end
  endtask

  task automatic t_bus();
    bus_resume = 1'b1; step(); bus_resume = 1'b0;
    check(irq_n, 1'b0, "R4 resume");
    plain_read();
    bus_reset = 1'b1; step(); bus_reset = 1'b0;
    check(irq_n, 1'b0, "R4 bus reset");
    plain_read();
    check(irq_n, 1'b1, "R7 clear after bus reset");
  endtask

  task automatic t_wake();
    wake_in = 1'b1; step(); step();
    check(irq_n, 1'b1, "R5 wake ignored without stop");
    stop_osc_cfg = 1'b1; step(); wake_in = 1'b0; stop_osc_cfg = 1'b0;
    check(irq_n, 1'b0, "R5 wake with stop-osc");
    plain_read();
    stop_clk_cfg = 1'b1; wake_in = 1'b1; step(); wake_in = 1'b0; stop_clk_cfg = 1'b0;
    check(irq_n, 1'b0, "R5 wake with stop-clk");
    plain_read();
    check(irq_n, 1'b1, "R5 cleared");
  endtask

  task automatic t_hold();
    done_flags = 3'b010; step(); done_flags = '0;
    step(); step(); step();
    check(irq_n, 1'b0, "R6 held after source drop");
    stat_rd_busy = 1'b1; step(); step();
    check(irq_n, 1'b0, "R6 low during read");
    stat_rd_end = 1'b1; step(); stat_rd_busy = 1'b0; stat_rd_end = 1'b0;
    check(irq_n, 1'b1, "R7 high after read end");
  endtask

  task automatic t_during();
    bus_resume = 1'b1; step(); bus_resume = 1'b0;
    stat_rd_busy = 1'b1; step();
    done_flags = 3'b100; step(); done_flags = '0; step();
    stat_rd_end = 1'b1; step(); stat_rd_busy = 1'b0; stat_rd_end = 1'b0;
    check(irq_n, 1'b0, "R8 held event pending after read");
    step(); step();
    check(irq_n, 1'b0, "R8 still pending");
    plain_read();
    check(irq_n, 1'b1, "R8 second read clears");
  endtask

  task automatic t_end_same();
    bus_reset = 1'b1; step(); bus_reset = 1'b0;
    stat_rd_busy = 1'b1; step();
    stat_rd_end = 1'b1; done_flags = 3'b001; step();
    stat_rd_busy = 1'b0; stat_rd_end = 1'b0; done_flags = '0;
    check(irq_n, 1'b0, "R9 event on read-end stays");
    plain_read();
    check(irq_n, 1'b1, "R9 later read clears");
  endtask

  task automatic t_merge();
    done_flags = 3'b111; bus_resume = 1'b1; step();
    done_flags = '0; bus_resume = 1'b0; bus_reset = 1'b1; step(); bus_reset = 1'b0;
    check(irq_n, 1'b0, "R10 merged pending");
    plain_read();
    check(irq_n, 1'b1, "R10 single read clears all");
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1; step();
    t_reset();
    t_release();
    t_done();
    t_bus();
    t_wake();
    t_hold();
    t_during();
    t_end_same();
    t_merge();
    done_run = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done_run) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule